// File: doc/BRIEF.md
# Byte-Window Frame Buffer Network Controller

A small network controller that sits behind a 32-bit register bus with a 64-byte address window. It keeps one received Ethernet frame and one outgoing frame, each in its own private byte buffer. Frames arrive on a byte stream with valid, ready and last signals. When the block is free to take a frame, the bytes land in the receive buffer. The CPU then drains them one byte per read of a single data register, and a count register tracks the bytes still unread.

To transmit, the CPU first writes a frame length and then writes the bytes one at a time to a single data register. When the last byte is written, the block streams the whole frame out on an outgoing byte stream and flags the completion. Completion events set bits in an interrupt control register, whose bits drive an interrupt line. A busy flag gates reception. The interrupt control register also carries a self-test bit: writing it alone soft-resets the block and raises an interrupt, and reading the register clears it.

Top module: `bytewin_nic`

## Requirements
- R1: After hardware reset, busy reads 1, both counts and interrupt control read 0, `irq` is low and `tx_valid` is low.
- R2: Only `bus_addr[5:0]` is decoded, so higher address bits alias. Offset 0x00 reads `ID_WORD0` and offset 0x04 reads `ID_WORD1`. By default these are the ASCII text "BYTE" and "NET0", with the first character in bits 7:0.
- R3: Offset 0x18, offset 0x20 and every unlisted offset read 0. Writes to the read-only registers (0x00, 0x04, 0x08, 0x0C, 0x18, 0x1C) and to unlisted offsets change nothing.
- R4: A frame of length L below `BUF_BYTES` that starts while busy is 0 is committed when its last byte arrives. The receive count (0x0C) becomes L, busy (0x08) becomes 1, and interrupt bit 1 (receive done) is set.
- R5: A frame is dropped with no change to any register if busy is 1 at its first byte, or if its length is `BUF_BYTES` or more.
- R6: Reading receive data (0x1C) while the count is nonzero returns the frame bytes in arrival order in bits 7:0 and decrements the count by one. While the count is 0, the read returns 0 and changes nothing.
- R7: Writing the transmit count (0x10) loads the value if it is at most `BUF_BYTES` and loads 0 otherwise. Either way it restarts the byte position of the frame being built.
- R8: Each accepted write to transmit data (0x20) stores bits 7:0. The write that brings the number of stored bytes up to the transmit count does three things: it zeroes the transmit count, sets interrupt bit 0 (transmit done) and sets busy. The frame then leaves on `tx_data` in write order, with `tx_last` on the final byte, and each byte is held while `tx_ready` is low.
- R9: Transmit data writes are ignored while a frame is streaming out and while the transmit count is 0.
- R10: A write to interrupt control (0x14) clears bit 0 if data bit 0 is set; otherwise it clears bit 1 if data bit 1 is set. Afterwards busy equals the OR of all interrupt bits.
- R11: A write to 0x14 with bits 0 and 1 clear and bit 31 set does the following: it zeroes both counts and all pointers, aborts any frame on `tx_data` and any partial receive, leaves interrupt control at 0x8000_0000 and sets busy to 1.
- R12: Reading 0x14 returns the current bits and then clears bit 31. A write of 0 sets busy to the OR of the remaining bits.
- R13: `irq` is high exactly when any interrupt control bit is set.
- R14: If a transmit completion and a receive commit happen in the same cycle, both take effect, and interrupt control reads 0x3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; low 6 bits decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Interrupt request |
| rx_valid | input | 1 | Incoming byte valid |
| rx_ready | output | 1 | Incoming byte accepted (always 1) |
| rx_data | input | 8 | Incoming byte |
| rx_last | input | 1 | Final byte of the incoming frame |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Sink takes the outgoing byte |
| tx_data | output | 8 | Outgoing byte |
| tx_last | output | 1 | Final byte of the outgoing frame |

## Verification
Two events can land in the same clock edge: the bus write that completes a transmit frame, and the arrival of the last byte of a receive frame. Each one sets its own interrupt bit and drives busy. The bench lines up the final transmit data write and the receive last byte on the same clock edge. It then expects interrupt control to read 0x3, the receive count to hold the new length, and the outgoing frame to be intact. After that, a write of 3 must clear only the transmit bit, which confirms the ordering between the two clear cases.

// File: rtl/bwn_pkg.sv
package bwn_pkg;
   localparam int OFS_W = 6;
   localparam logic [OFS_W-1:0] OFS_ID0   = 6'h00;
   localparam logic [OFS_W-1:0] OFS_ID1   = 6'h04;
   localparam logic [OFS_W-1:0] OFS_BUSY  = 6'h08;
   localparam logic [OFS_W-1:0] OFS_RXCNT = 6'h0C;
   localparam logic [OFS_W-1:0] OFS_TXCNT = 6'h10;
   localparam logic [OFS_W-1:0] OFS_CTL   = 6'h14;
   localparam logic [OFS_W-1:0] OFS_INFO  = 6'h18;
   localparam logic [OFS_W-1:0] OFS_RXDAT = 6'h1C;
   localparam logic [OFS_W-1:0] OFS_TXDAT = 6'h20;

   localparam int BIT_TXDONE = 0;
   localparam int BIT_RXDONE = 1;
   localparam int BIT_TEST   = 31;

   typedef struct packed {
      logic test;
      logic rx_done;
      logic tx_done;
   } irq_bits_t;
endpackage

// File: rtl/bwn_rx_store.sv
module bwn_rx_store #(
   parameter int BUF_BYTES = 1514,
   localparam int CW = $clog2(BUF_BYTES + 1),
   localparam int PW = $clog2(BUF_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_rst,
   input  logic          busy,
   input  logic          in_valid,
   input  logic [7:0]    in_data,
   input  logic          in_last,
   input  logic          rd_req,
   output logic [7:0]    rd_byte,
   output logic [CW-1:0] count,
   output logic          commit
);
   logic [7:0]    mem [BUF_BYTES];
   logic [PW-1:0] wptr, rptr, idx;
   logic          in_frame, keep, keep_now, fits, store;
   logic [CW-1:0] cnt_q;

   // The first byte of a frame decides whether the frame is taken at all.
   always_comb begin
      idx      = in_frame ? wptr : '0;
      keep_now = in_frame ? keep : (!busy && (int'(cnt_q) < BUF_BYTES));
      fits     = int'(idx) < BUF_BYTES - 1;
      store    = in_valid && keep_now && fits && !soft_rst;
      commit   = store && in_last && !busy;
   end

   always_ff @(posedge clk) begin
      if (store) mem[idx] <= in_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || soft_rst) begin
         wptr     <= '0;
         rptr     <= '0;
         in_frame <= 1'b0;
         keep     <= 1'b0;
         cnt_q    <= '0;
         rd_byte  <= '0;
      end else begin
         if (in_valid) begin
            if (in_last) begin
               in_frame <= 1'b0;
               keep     <= 1'b0;
               wptr     <= '0;
            end else begin
               in_frame <= 1'b1;
               keep     <= keep_now && fits;
               wptr     <= store ? idx + PW'(1) : idx;
            end
         end
         if (rd_req) rd_byte <= (cnt_q != '0) ? mem[rptr] : 8'h00;
         if (commit) begin
            cnt_q <= CW'(int'(idx) + 1);
            rptr  <= '0;
         end else if (rd_req && cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
            rptr  <= rptr + PW'(1);
         end
      end
   end

   assign count = cnt_q;

   assert_read_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && cnt_q == '0 && !commit && !soft_rst) |=> (cnt_q == '0));
   assert_read_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && cnt_q != '0 && !commit && !soft_rst) |=> (cnt_q == $past(cnt_q) - CW'(1)));
   assert_drop_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_frame && busy && !soft_rst && !rd_req) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/bwn_tx_store.sv
module bwn_tx_store #(
   parameter int BUF_BYTES = 1514,
   localparam int CW = $clog2(BUF_BYTES + 1),
   localparam int PW = $clog2(BUF_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_rst,
   input  logic          len_wr,
   input  logic          data_wr,
   input  logic [31:0]   wdata,
   output logic [CW-1:0] count,
   output logic          done,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [7:0]    out_data,
   output logic          out_last
);
   logic [7:0]    mem [BUF_BYTES];
   logic [CW-1:0] cnt_q, slen;
   logic [PW-1:0] wptr, sptr;
   logic          sending, wr_ok;

   always_comb begin
      wr_ok = data_wr && !sending && cnt_q != '0 && !soft_rst;
      done  = wr_ok && ((32'(wptr) + 32'd1) == 32'(cnt_q));
   end

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wptr] <= wdata[7:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n || soft_rst) begin
         cnt_q   <= '0;
         slen    <= '0;
         wptr    <= '0;
         sptr    <= '0;
         sending <= 1'b0;
      end else begin
         if (len_wr) begin
            cnt_q <= (wdata <= 32'(BUF_BYTES)) ? CW'(wdata) : '0;
            wptr  <= '0;
         end else if (wr_ok) begin
            if (done) begin
               slen    <= cnt_q;
               sending <= 1'b1;
               sptr    <= '0;
               cnt_q   <= '0;
               wptr    <= '0;
            end else begin
               wptr <= wptr + PW'(1);
            end
         end
         if (sending && out_ready) begin
            if (out_last) begin
               sending <= 1'b0;
               sptr    <= '0;
            end else begin
               sptr <= sptr + PW'(1);
            end
         end
      end
   end

   assign count     = cnt_q;
   assign out_valid = sending;
   assign out_data  = mem[sptr];
   assign out_last  = sending && ((32'(sptr) + 32'd1) == 32'(slen));

   assert_len_clip_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (len_wr && wdata > 32'(BUF_BYTES)) |=> (cnt_q == '0));
   assert_hold_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !soft_rst) |=> (out_valid && $stable(out_data) && $stable(out_last)));
   assert_ignore_busy_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && sending) |=> (wptr == $past(wptr)));
endmodule

// File: rtl/bytewin_nic.sv
module bytewin_nic
   import bwn_pkg::*;
#(
   parameter int          BUF_BYTES = 1514,
   parameter int          ADDR_W    = 8,
   parameter logic [31:0] ID_WORD0  = 32'h4554_5942,
   parameter logic [31:0] ID_WORD1  = 32'h3054_454E,
   localparam int         CW        = $clog2(BUF_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq,
   input  logic              rx_valid,
   output logic              rx_ready,
   input  logic [7:0]        rx_data,
   input  logic              rx_last,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [7:0]        tx_data,
   output logic              tx_last
);
   if (BUF_BYTES < 2) begin : g_bad_buf
      $error("BUF_BYTES must be at least 2");
   end
   if (ADDR_W < OFS_W) begin : g_bad_addr
      $error("ADDR_W must cover the 6-bit register window");
   end

   logic unused_addr_hi;
   if (ADDR_W > OFS_W) begin : g_addr_wide
      assign unused_addr_hi = ^bus_addr[ADDR_W-1:OFS_W];
   end else begin : g_addr_exact
      assign unused_addr_hi = 1'b0;
   end

   logic [OFS_W-1:0] off;
   logic             rd, ctl_wr, soft_rst;
   logic             rx_commit, tx_done, rx_sel_q, busy_q, busy_nx;
   logic [7:0]       rx_byte;
   logic [CW-1:0]    rx_count, tx_count;
   irq_bits_t        ie_q, ie_nx;
   logic [31:0]      rdata_q, rd_mux, ctl_val;

   assign off      = bus_addr[OFS_W-1:0];
   assign rd       = bus_sel && !bus_wr;
   assign ctl_wr   = bus_sel && bus_wr && off == OFS_CTL;
   assign soft_rst = ctl_wr && !bus_wdata[BIT_TXDONE] && !bus_wdata[BIT_RXDONE]
                     && bus_wdata[BIT_TEST];
   assign ctl_val  = {ie_q.test, 29'b0, ie_q.rx_done, ie_q.tx_done};

   bwn_rx_store #(.BUF_BYTES(BUF_BYTES)) u_rx (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .busy(busy_q),
      .in_valid(rx_valid), .in_data(rx_data), .in_last(rx_last),
      .rd_req(rd && off == OFS_RXDAT), .rd_byte(rx_byte),
      .count(rx_count), .commit(rx_commit)
   );

   bwn_tx_store #(.BUF_BYTES(BUF_BYTES)) u_tx (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .len_wr(bus_sel && bus_wr && off == OFS_TXCNT),
      .data_wr(bus_sel && bus_wr && off == OFS_TXDAT),
      .wdata(bus_wdata), .count(tx_count), .done(tx_done),
      .out_valid(tx_valid), .out_ready(tx_ready),
      .out_data(tx_data), .out_last(tx_last)
   );

   // Bus effects first, completion events merged on top of them.
   always_comb begin
      ie_nx = ie_q;
      if (rd && off == OFS_CTL) ie_nx.test = 1'b0;
      if (ctl_wr) begin
         if (bus_wdata[BIT_TXDONE])      ie_nx.tx_done = 1'b0;
         else if (bus_wdata[BIT_RXDONE]) ie_nx.rx_done = 1'b0;
         else if (bus_wdata[BIT_TEST])   ie_nx = '{test: 1'b1, rx_done: 1'b0, tx_done: 1'b0};
      end
      if (!soft_rst) begin
         ie_nx.tx_done = ie_nx.tx_done | tx_done;
         ie_nx.rx_done = ie_nx.rx_done | rx_commit;
      end
      if (soft_rst)                   busy_nx = 1'b1;
      else if (ctl_wr)                busy_nx = |ie_nx;
      else if (tx_done || rx_commit)  busy_nx = 1'b1;
      else                            busy_nx = busy_q;
   end

   always_comb begin
      case (off)
         OFS_ID0:   rd_mux = ID_WORD0;
         OFS_ID1:   rd_mux = ID_WORD1;
         OFS_BUSY:  rd_mux = {31'b0, busy_q};
         OFS_RXCNT: rd_mux = 32'(rx_count);
         OFS_TXCNT: rd_mux = 32'(tx_count);
         OFS_CTL:   rd_mux = ctl_val;
         default:   rd_mux = 32'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ie_q     <= '0;
         busy_q   <= 1'b1;
         rdata_q  <= '0;
         rx_sel_q <= 1'b0;
      end else begin
         ie_q   <= ie_nx;
         busy_q <= busy_nx;
         if (rd) begin
            rdata_q  <= rd_mux;
            rx_sel_q <= (off == OFS_RXDAT);
         end
      end
   end

   assign bus_rdata = rx_sel_q ? {24'b0, rx_byte} : rdata_q;
   assign irq       = ie_q.test | ie_q.rx_done | ie_q.tx_done;
   assign rx_ready  = 1'b1;

   assert_commit_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_commit && !soft_rst) |=> (ie_q.rx_done && busy_q));
   assert_tx_prio_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && bus_wdata[BIT_TXDONE]) |=> !ie_q.tx_done);
   assert_soft_rst_R11: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (busy_q && ie_q.test && !ie_q.rx_done && !ie_q.tx_done && !tx_valid));
   assert_test_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && off == OFS_CTL) |=> !ie_q.test);
endmodule

// File: tb/bytewin_nic_tb.sv
`timescale 1ns/1ps
module bytewin_nic_tb;
   localparam int BUF = 16;

   logic        clk = 1'b0;
   logic        rst_n, sel, we;
   logic [7:0]  addr;
   logic [31:0] wdata, rdata;
   logic        irq, rx_valid, rx_ready, rx_last, tx_valid, tx_ready, tx_last;
   logic [7:0]  rx_data, tx_data;

   int n_chk = 0, n_fail = 0, tot_n = 0, rdy_mode = 0;
   logic [7:0] cap_b [64];
   logic       cap_l [64];

   always #4 clk = ~clk;

   bytewin_nic #(.BUF_BYTES(BUF), .ADDR_W(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(we), .bus_addr(addr),
      .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq),
      .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last)
   );

   always @(posedge clk)
      tx_ready <= (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? 1'b0 : ~tx_ready;

   always @(negedge clk)
      if (tx_valid && tx_ready) begin
         cap_b[tot_n % 64] = tx_data;
         cap_l[tot_n % 64] = tx_last;
         tot_n++;
      end

   function automatic logic [7:0] fb(int s, int i);
      return 8'(s * 29 + i * 17 + 3);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bwr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); sel = 1; we = 1; addr = a; wdata = d;
      @(negedge clk); sel = 0; we = 0;
   endtask

   task automatic brd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); sel = 1; we = 0; addr = a;
      @(negedge clk); sel = 0; d = rdata;
   endtask

   task automatic expect_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] d;
      brd(a, d);
      check(req, d, exp);
   endtask

   task automatic send_frame(input int len, input int seed);
      for (int i = 0; i < len; i++) begin
         @(negedge clk); rx_valid = 1; rx_data = fb(seed, i); rx_last = (i == len - 1);
      end
      @(negedge clk); rx_valid = 0; rx_last = 0;
   endtask

   task automatic check_frame(input string req, input int base, input int len, input int seed);
      for (int t = 0; t < 400 && tot_n - base < len; t++) @(negedge clk);
      check(req, 32'(tot_n - base), 32'(len));
      for (int i = 0; i < len; i++) begin
         check(req, {24'b0, cap_b[(base + i) % 64]}, {24'b0, fb(seed, i)});
         check(req, {31'b0, cap_l[(base + i) % 64]}, {31'b0, (i == len - 1)});
      end
   endtask

   task automatic tx_bytes(input int seed, input int from, input int upto);
      for (int i = from; i < upto; i++) bwr(8'h20, {24'hABCDEE, fb(seed, i)});
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
      finish_run();
   end

   initial begin
      int base;
      rst_n = 0; sel = 0; we = 0; addr = 0; wdata = 0;
      rx_valid = 0; rx_data = 0; rx_last = 0;
      repeat (5) @(negedge clk);
      rst_n = 1;

      // R1 reset state
      expect_rd("R1 busy", 8'h08, 1);
      expect_rd("R1 rxcnt", 8'h0C, 0);
      expect_rd("R1 txcnt", 8'h10, 0);
      expect_rd("R1 ctl", 8'h14, 0);
      check("R1 irq", {31'b0, irq}, 0);
      check("R1 tx_valid", {31'b0, tx_valid}, 0);

      // R2 identity words and aliasing
      expect_rd("R2 id0", 8'h00, 32'h4554_5942);
      expect_rd("R2 id1", 8'h04, 32'h3054_454E);
      expect_rd("R2 alias id0", 8'h40, 32'h4554_5942);
      expect_rd("R2 alias id1", 8'hC4, 32'h3054_454E);
      expect_rd("R2 alias busy", 8'h48, 1);

      // R3 zero-reading offsets
      expect_rd("R3 info", 8'h18, 0);
      expect_rd("R3 txdat", 8'h20, 0);
      expect_rd("R3 unlisted 24", 8'h24, 0);
      expect_rd("R3 unlisted 3C", 8'h3C, 0);
      expect_rd("R3 unaligned", 8'h01, 0);

      // R5 frame while busy is dropped
      send_frame(3, 1);
      expect_rd("R5 busy drop cnt", 8'h0C, 0);
      expect_rd("R5 busy drop ctl", 8'h14, 0);

      // R12 zero write acknowledges: busy = OR of bits = 0
      bwr(8'h14, 0);
      expect_rd("R12 ack busy", 8'h08, 0);

      // R5 oversize frames dropped
      send_frame(BUF, 2);
      expect_rd("R5 len=BUF cnt", 8'h0C, 0);
      expect_rd("R5 len=BUF ctl", 8'h14, 0);
      send_frame(BUF + 1, 3);
      expect_rd("R5 len>BUF cnt", 8'h0C, 0);
      expect_rd("R5 len>BUF busy", 8'h08, 0);
      check("R5 irq", {31'b0, irq}, 0);

      // R4/R6/R10/R13 receive sweep
      for (int L = 1; L < BUF; L++) begin
         send_frame(L, 10 + L);
         expect_rd("R4 cnt", 8'h0C, 32'(L));
         expect_rd("R4 ctl", 8'h14, 2);
         expect_rd("R4 busy", 8'h08, 1);
         check("R13 irq rx", {31'b0, irq}, 1);
         if (L == 4) begin
            bwr(8'h0C, 9); bwr(8'h08, 0); bwr(8'h00, 5); bwr(8'h30, 7);
            expect_rd("R3 ro cnt", 8'h0C, 4);
            expect_rd("R3 ro busy", 8'h08, 1);
            expect_rd("R3 ro id", 8'h00, 32'h4554_5942);
         end
         for (int i = 0; i < L; i++) begin
            expect_rd("R6 byte", 8'h1C, {24'b0, fb(10 + L, i)});
            expect_rd("R6 dec", 8'h0C, 32'(L - i - 1));
         end
         expect_rd("R6 empty read", 8'h1C, 0);
         expect_rd("R6 empty cnt", 8'h0C, 0);
         bwr(8'h14, 2);
         expect_rd("R10 rx clear", 8'h14, 0);
         expect_rd("R10 busy", 8'h08, 0);
         check("R13 irq low", {31'b0, irq}, 0);
      end

      // R7 transmit count loading
      bwr(8'h10, BUF + 1);
      expect_rd("R7 over", 8'h10, 0);
      bwr(8'h10, 32'hFFFF_FFFF);
      expect_rd("R7 huge", 8'h10, 0);
      bwr(8'h10, BUF);
      expect_rd("R7 max", 8'h10, BUF);

      // R8 transmit sweep with alternating backpressure
      rdy_mode = 2;
      for (int L = 1; L <= BUF; L++) begin
         base = tot_n;
         bwr(8'h10, L);
         tx_bytes(40 + L, 0, L);
         expect_rd("R8 cnt zero", 8'h10, 0);
         expect_rd("R8 ctl", 8'h14, 1);
         expect_rd("R8 busy", 8'h08, 1);
         check("R13 irq tx", {31'b0, irq}, 1);
         check_frame("R8 frame", base, L, 40 + L);
         bwr(8'h14, 1);
         expect_rd("R10 tx clear", 8'h14, 0);
         expect_rd("R10 busy tx", 8'h08, 0);
      end
      rdy_mode = 0;

      // R7 count rewrite restarts position
      base = tot_n;
      bwr(8'h10, 4); tx_bytes(80, 0, 2);
      bwr(8'h10, 2); tx_bytes(81, 0, 2);
      check_frame("R7 restart", base, 2, 81);
      bwr(8'h14, 1);

      // R9 writes with count zero ignored
      bwr(8'h20, 8'h77);
      expect_rd("R9 zero count", 8'h14, 0);
      check("R9 no stream", {31'b0, tx_valid}, 0);

      // R9 writes while streaming ignored
      rdy_mode = 1;
      base = tot_n;
      bwr(8'h10, 3); tx_bytes(90, 0, 3);
      check("R8 valid held", {31'b0, tx_valid}, 1);
      bwr(8'h10, 3); bwr(8'h20, 8'h99);
      rdy_mode = 0;
      check_frame("R9 first", base, 3, 90);
      bwr(8'h14, 1);
      base = tot_n;
      tx_bytes(91, 0, 2);
      expect_rd("R9 not done", 8'h14, 0);
      tx_bytes(91, 2, 3);
      check_frame("R9 second", base, 3, 91);
      expect_rd("R9 done", 8'h14, 1);

      // R10 bit0 wins over bit31
      bwr(8'h14, 32'h8000_0001);
      expect_rd("R10 prio test", 8'h14, 0);
      expect_rd("R10 prio busy", 8'h08, 0);

      // R14 transmit completion and receive commit in one cycle
      base = tot_n;
      bwr(8'h10, 2); tx_bytes(60, 0, 1);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); rx_valid = 1; rx_data = fb(50, i); rx_last = 0;
      end
      @(negedge clk);
      rx_valid = 1; rx_data = fb(50, 3); rx_last = 1;
      sel = 1; we = 1; addr = 8'h20; wdata = {24'h0, fb(60, 1)};
      @(negedge clk);
      rx_valid = 0; rx_last = 0; sel = 0; we = 0;
      expect_rd("R14 ctl both", 8'h14, 3);
      expect_rd("R14 rx cnt", 8'h0C, 4);
      expect_rd("R14 busy", 8'h08, 1);
      check_frame("R14 tx frame", base, 2, 60);
      bwr(8'h14, 3);
      expect_rd("R10 only tx cleared", 8'h14, 2);
      expect_rd("R10 busy kept", 8'h08, 1);
      expect_rd("R14 rx byte0", 8'h1C, {24'b0, fb(50, 0)});
      bwr(8'h14, 2);
      expect_rd("R10 both clear busy", 8'h08, 0);

      // R11 soft reset clears counts and sets test bit
      send_frame(3, 70);
      bwr(8'h10, 5); tx_bytes(71, 0, 2);
      bwr(8'h14, 32'h8000_0000);
      check("R13 irq test", {31'b0, irq}, 1);
      expect_rd("R11 rxcnt", 8'h0C, 0);
      expect_rd("R11 txcnt", 8'h10, 0);
      expect_rd("R11 busy", 8'h08, 1);
      expect_rd("R12 ctl read", 8'h14, 32'h8000_0000);
      expect_rd("R12 test cleared", 8'h14, 0);
      check("R13 irq after read", {31'b0, irq}, 0);
      bwr(8'h14, 0);
      expect_rd("R12 ack busy", 8'h08, 0);

      // R11 soft reset aborts an outgoing frame
      rdy_mode = 1;
      bwr(8'h10, 3); tx_bytes(72, 0, 3);
      check("R11 streaming", {31'b0, tx_valid}, 1);
      bwr(8'h14, 32'h8000_0000);
      check("R11 abort", {31'b0, tx_valid}, 0);
      expect_rd("R11 ctl", 8'h14, 32'h8000_0000);
      bwr(8'h14, 0);
      rdy_mode = 0;
      base = tot_n;
      bwr(8'h10, 2); tx_bytes(73, 0, 2);
      check_frame("R11 after reset", base, 2, 73);

      finish_run();
   end
endmodule